// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs the external bus cycles of a small 8-bit processor that has a 20-bit address space. An internal requester gives it one transfer at a time: a start strobe, a direction, a memory-or-I/O select, the address, the write byte, a two-bit segment class and the live interrupt-enable flag. The sequencer then steps through T1, T2, T3, any number of wait states (Tw) and T4. It drives a low byte that is shared between address and data, a middle address byte, and a top nibble that carries address in T1 and status after T1. It also drives an address latch strobe and active-low read and write strobes.

A slow device stretches a cycle by holding the ready input low. Read data is captured from the shared lines and returned with a one-cycle done pulse. An external master can take the bus through a hold request and acknowledge. Tri-state pins are modelled as a separate output-enable per pin group.

All outputs are registered. Each output shows the value that belongs to the state the sequencer occupies in that clock.

Top module: `bus_cycle_seq`

## Requirements
- R1: A cycle runs T1, T2, T3, zero or more Tw, then T4, then at least one idle clock. `req_start` is accepted only when the block is idle and `hold_req` is low; at any other time it is ignored. `ale` is high in T1 and in no other state.
- R2: `ad_oe` is high in T1, with `ad_out` = address bits 7..0. In a write cycle it stays high from T2 to T4 with `ad_out` = write byte. In a read cycle it is low from T2 on.
- R3: `a_mid` carries address bits 15..8, and `a_mid_oe` is high from T1 through T4.
- R4: In T1, `as_out` is address bits 19..16 for a memory cycle (`req_mem`=1) and 0000 for an I/O cycle. `as_oe` is high from T1 through T4.
- R5: From T2 through T4, `as_out` has bit 3 = 0 and bit 2 = `req_ie` as sampled at the clock edge that starts that state. Bits 1..0 are the segment class latched at start: 00 alternate data, 01 stack, 10 code or none, 11 data.
- R6: In a read cycle, `rd_n` is low in T2, T3 and Tw and high elsewhere. It is never low in a clock where `ad_oe` is high.
- R7: In a write cycle, `wr_n` is low in T2, T3 and Tw and high elsewhere. `rd_n` and `wr_n` are never low together.
- R8: `bus_ready` is sampled at the edge that ends T3 and at the edge that ends each Tw. When it is low the next state is Tw; when it is high the next state is T4.
- R9: In a read cycle, `rsp_rdata` takes `ad_in` at the edge where ready is sampled high. `rsp_done` is high for exactly the one clock after T4.
- R10: Hold is granted only from idle or at the end of T4. `hold_ack` stays high while `hold_req` is high. While `hold_ack` is high, `ad_oe`, `a_mid_oe`, `as_oe` and `rd_oe` are low. `rd_oe` is high in every other non-reset clock.
- R11: With `rst` high, all output enables, `ale`, `hold_ack`, `rsp_done` and `rsp_rdata` are 0, and `rd_n` and `wr_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start a bus cycle (accepted only when idle, no hold) |
| req_read | input | 1 | 1 = read, 0 = write |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 8 | Write byte |
| req_seg | input | 2 | Segment class code |
| req_ie | input | 1 | Interrupt-enable flag, sampled every clock |
| rsp_rdata | output | 8 | Captured read byte |
| rsp_done | output | 1 | One-clock pulse after T4 |
| bus_ready | input | 1 | Device ready, active high |
| hold_req | input | 1 | External bus request |
| hold_ack | output | 1 | Bus released to the external master |
| ad_in | input | 8 | Shared low lines, input side |
| ad_out | output | 8 | Shared low lines, output side |
| ad_oe | output | 1 | Enable for `ad_out` |
| a_mid | output | 8 | Address bits 15..8 |
| a_mid_oe | output | 1 | Enable for `a_mid` |
| as_out | output | 4 | Address 19..16 in T1, status after |
| as_oe | output | 1 | Enable for `as_out` |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| rd_oe | output | 1 | Enable for `rd_n` |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A wrong state register shows at the pins in the same clock. A skipped or repeated phase moves `ale` or a strobe by a whole clock, or leaves a Tw that ready did not ask for. A stale request latch, or a bad status mux, puts the wrong byte or nibble on a group whose enable is high, in T1 or T2 of the first cycle after the fault. An early hold grant drops the enables in the middle of a cycle. A missed capture shows as a wrong `rsp_rdata` in the clock where `rsp_done` is high.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_st_e;

  localparam logic [1:0] SEG_ALT   = 2'b00;
  localparam logic [1:0] SEG_STACK = 2'b01;
  localparam logic [1:0] SEG_CODE  = 2'b10;
  localparam logic [1:0] SEG_DATA  = 2'b11;
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    ready,
  input  logic    hold_req,
  output bus_st_e st_q,
  output bus_st_e st_nx,
  output logic    accept,
  output logic    hold_ack,
  output logic    done
);
  assign accept = (st_q == ST_IDLE) && start && !hold_req;

  always_comb begin
    st_nx = st_q;
    case (st_q)
      ST_IDLE: if (hold_req) st_nx = ST_HOLD;
               else if (start) st_nx = ST_T1;
      ST_T1:   st_nx = ST_T2;
      ST_T2:   st_nx = ST_T3;
      ST_T3:   st_nx = ready ? ST_T4 : ST_TW;
      ST_TW:   st_nx = ready ? ST_T4 : ST_TW;
      ST_T4:   st_nx = hold_req ? ST_HOLD : ST_IDLE;
      ST_HOLD: if (!hold_req) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      hold_ack <= 1'b0;
      done     <= 1'b0;
    end else begin
      st_q     <= st_nx;
      hold_ack <= (st_nx == ST_HOLD);
      done     <= (st_q == ST_T4);
    end
  end

  // R8
  wait_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_T3 && !ready) |=> (st_q == ST_TW));

  // R9
  done_after_t4_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_T4) |=> done);

  // R10
  hold_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> ($past(st_q) == ST_IDLE || $past(st_q) == ST_T4));
endmodule

// File: rtl/bus_seq_req.sv
module bus_seq_req
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  bus_st_e           st_q,
  input  logic              ready,
  input  logic              in_rd,
  input  logic              in_mem,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [1:0]        in_seg,
  input  logic [DATA_W-1:0] ad_in,
  output logic              cur_rd,
  output logic              cur_mem,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic [1:0]        cur_seg,
  output logic [DATA_W-1:0] rdata
);
  logic              lat_rd, lat_mem;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic [1:0]        lat_seg;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_rd    <= 1'b1;
      lat_mem   <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_seg   <= SEG_CODE;
      rdata     <= '0;
    end else begin
      if (accept) begin
        lat_rd    <= in_rd;
        lat_mem   <= in_mem;
        lat_addr  <= in_addr;
        lat_wdata <= in_wdata;
        lat_seg   <= in_seg;
      end
      if ((st_q == ST_T3 || st_q == ST_TW) && ready && lat_rd)
        rdata <= ad_in;
    end
  end

  // the output register for T1 must see the request in the same edge it is latched
  assign cur_rd    = accept ? in_rd    : lat_rd;
  assign cur_mem   = accept ? in_mem   : lat_mem;
  assign cur_addr  = accept ? in_addr  : lat_addr;
  assign cur_wdata = accept ? in_wdata : lat_wdata;
  assign cur_seg   = accept ? in_seg   : lat_seg;
endmodule

// File: rtl/bus_seq_pins.sv
module bus_seq_pins
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int TOP_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_st_e           st_nx,
  input  logic              cur_rd,
  input  logic              cur_mem,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic [1:0]        cur_seg,
  input  logic              ie,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-TOP_W-1:0] a_mid,
  output logic              a_mid_oe,
  output logic [TOP_W-1:0]  as_out,
  output logic              as_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              rd_oe,
  output logic              wr_n
);
  localparam int MID_W = ADDR_W - DATA_W - TOP_W;

  logic is_t1, in_cyc, strobe_ph, data_ph;
  logic [DATA_W-1:0] ad_d;
  logic [TOP_W-1:0]  as_d;

  always_comb begin
    is_t1     = (st_nx == ST_T1);
    strobe_ph = (st_nx inside {ST_T2, ST_T3, ST_TW});
    data_ph   = strobe_ph || (st_nx == ST_T4);
    in_cyc    = is_t1 || data_ph;
    ad_d      = is_t1 ? cur_addr[DATA_W-1:0] : cur_wdata;
    if (is_t1)
      as_d = cur_mem ? cur_addr[ADDR_W-1 -: TOP_W] : '0;
    else
      as_d = TOP_W'({1'b0, ie, cur_seg});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out   <= '0;
      ad_oe    <= 1'b0;
      a_mid    <= '0;
      a_mid_oe <= 1'b0;
      as_out   <= '0;
      as_oe    <= 1'b0;
      ale      <= 1'b0;
      rd_n     <= 1'b1;
      rd_oe    <= 1'b0;
      wr_n     <= 1'b1;
    end else begin
      ad_out   <= ad_d;
      ad_oe    <= is_t1 || (data_ph && !cur_rd);
      a_mid    <= cur_addr[DATA_W +: MID_W];
      a_mid_oe <= in_cyc;
      as_out   <= as_d;
      as_oe    <= in_cyc;
      ale      <= is_t1;
      rd_n     <= !(strobe_ph && cur_rd);
      rd_oe    <= (st_nx != ST_HOLD);
      wr_n     <= !(strobe_ph && !cur_rd);
    end
  end

  // R6
  rd_no_contend_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> wr_n);

  // R1
  ale_single_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R5
  status_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (as_oe && !ale) |-> (as_out[TOP_W-1] == 1'b0));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int TOP_W  = 4,
  localparam int MID_W = ADDR_W - DATA_W - TOP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic              req_read,
  input  logic              req_mem,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_seg,
  input  logic              req_ie,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  input  logic              bus_ready,
  input  logic              hold_req,
  output logic              hold_ack,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [MID_W-1:0]  a_mid,
  output logic              a_mid_oe,
  output logic [TOP_W-1:0]  as_out,
  output logic              as_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              rd_oe,
  output logic              wr_n
);
  bus_st_e st_q, st_nx;
  logic accept, c_rd, c_mem;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_wdata;
  logic [1:0] c_seg;

  bus_seq_fsm fsm_i (
    .clk(clk), .rst(rst), .start(req_start), .ready(bus_ready),
    .hold_req(hold_req), .st_q(st_q), .st_nx(st_nx), .accept(accept),
    .hold_ack(hold_ack), .done(rsp_done)
  );

  bus_seq_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) req_i (
    .clk(clk), .rst(rst), .accept(accept), .st_q(st_q), .ready(bus_ready),
    .in_rd(req_read), .in_mem(req_mem), .in_addr(req_addr),
    .in_wdata(req_wdata), .in_seg(req_seg), .ad_in(ad_in),
    .cur_rd(c_rd), .cur_mem(c_mem), .cur_addr(c_addr),
    .cur_wdata(c_wdata), .cur_seg(c_seg), .rdata(rsp_rdata)
  );

  bus_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_W(TOP_W)) pins_i (
    .clk(clk), .rst(rst), .st_nx(st_nx), .cur_rd(c_rd), .cur_mem(c_mem),
    .cur_addr(c_addr), .cur_wdata(c_wdata), .cur_seg(c_seg), .ie(req_ie),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_mid(a_mid), .a_mid_oe(a_mid_oe),
    .as_out(as_out), .as_oe(as_oe), .ale(ale), .rd_n(rd_n), .rd_oe(rd_oe),
    .wr_n(wr_n)
  );

  // R10
  hold_float_chk: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> !(ad_oe || a_mid_oe || as_oe || rd_oe));
endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_start = 0, req_read = 1, req_mem = 1, req_ie = 0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [1:0]  req_seg = 2'b00;
  logic bus_ready = 1, hold_req = 0;
  logic [7:0] ad_in = '0;
  logic [7:0] rsp_rdata, ad_out, a_mid;
  logic [3:0] as_out;
  logic rsp_done, hold_ack, ad_oe, a_mid_oe, as_oe, ale, rd_n, rd_oe, wr_n;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  bus_cycle_seq dut_i (
    .clk(clk), .rst(rst), .req_start(req_start), .req_read(req_read),
    .req_mem(req_mem), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_seg(req_seg), .req_ie(req_ie), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .bus_ready(bus_ready), .hold_req(hold_req),
    .hold_ack(hold_ack), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .a_mid(a_mid), .a_mid_oe(a_mid_oe), .as_out(as_out), .as_oe(as_oe),
    .ale(ale), .rd_n(rd_n), .rd_oe(rd_oe), .wr_n(wr_n)
  );

  // reference model: phase 0 idle, 1 T1, 2 T2, 3 T3, 4 Tw, 5 T4, 6 hold
  int ph = 0;
  logic m_rd, m_mem;
  logic [19:0] m_addr;
  logic [7:0]  m_wd;
  logic [1:0]  m_seg;
  logic e_ale, e_rdn, e_wrn, e_adoe, e_midoe, e_asoe, e_rdoe, e_hold, e_done;
  logic [7:0] e_ad, e_mid, e_rdata;
  logic [3:0] e_as;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int nph;
    if (rst) begin
      ph = 0; e_ale = 0; e_rdn = 1; e_wrn = 1; e_adoe = 0; e_midoe = 0;
      e_asoe = 0; e_rdoe = 0; e_hold = 0; e_done = 0; e_rdata = 0;
    end else begin
      nph = ph;
      e_done = (ph == 5);
      if ((ph == 3 || ph == 4) && bus_ready && m_rd) e_rdata = ad_in;
      if (ph == 0) begin
        if (hold_req) nph = 6;
        else if (req_start) begin
          nph = 1; m_rd = req_read; m_mem = req_mem; m_addr = req_addr;
          m_wd = req_wdata; m_seg = req_seg;
        end
      end else if (ph == 1) nph = 2;
      else if (ph == 2) nph = 3;
      else if (ph == 3 || ph == 4) nph = bus_ready ? 5 : 4;
      else if (ph == 5) nph = hold_req ? 6 : 0;
      else if (ph == 6 && !hold_req) nph = 0;
      ph = nph;
      e_ale   = (ph == 1);
      e_rdn   = !(m_rd && ph >= 2 && ph <= 4);
      e_wrn   = !(!m_rd && ph >= 2 && ph <= 4);
      e_midoe = (ph >= 1 && ph <= 5);
      e_asoe  = e_midoe;
      e_adoe  = (ph == 1) || (!m_rd && ph >= 2 && ph <= 5);
      e_rdoe  = (ph != 6);
      e_hold  = (ph == 6);
      e_ad    = (ph == 1) ? m_addr[7:0] : m_wd;
      e_mid   = m_addr[15:8];
      e_as    = (ph == 1) ? (m_mem ? m_addr[19:16] : 4'h0) : {1'b0, req_ie, m_seg};
    end
    #1;
    if (rst) begin
      chk("R11 ale", ale, 0); chk("R11 rd_n", rd_n, 1); chk("R11 wr_n", wr_n, 1);
      chk("R11 oe", {ad_oe, a_mid_oe, as_oe, rd_oe}, 0);
      chk("R11 hold/done", {hold_ack, rsp_done}, 0); chk("R11 rdata", rsp_rdata, 0);
    end else begin
      chk("R1 ale", ale, e_ale);
      chk("R6 R8 rd_n", rd_n, e_rdn);
      chk("R7 R8 wr_n", wr_n, e_wrn);
      chk("R2 ad_oe", ad_oe, e_adoe);
      chk("R3 a_mid_oe", a_mid_oe, e_midoe);
      chk("R4 as_oe", as_oe, e_asoe);
      chk("R10 rd_oe", rd_oe, e_rdoe);
      chk("R10 hold_ack", hold_ack, e_hold);
      chk("R9 done", rsp_done, e_done);
      if (e_adoe) chk("R2 ad_out", ad_out, e_ad);
      if (e_midoe) chk("R3 a_mid", a_mid, e_mid);
      if (e_asoe) chk(e_ale ? "R4 as_out" : "R5 as_out", as_out, e_as);
      if (e_done) chk("R9 rdata", rsp_rdata, e_rdata);
    end
  end

  // drives one cycle; stray_start re-pulses start mid-cycle (R1), hold_mid raises hold in T2
  task automatic run_cycle(input logic rd, input logic mem, input logic [19:0] a,
                           input logic [7:0] wd, input logic [1:0] sg, input int waits,
                           input bit stray_start, input bit hold_mid);
    @(negedge clk);
    req_start = 1; req_read = rd; req_mem = mem; req_addr = a;
    req_wdata = wd; req_seg = sg; bus_ready = (waits == 0);
    for (int i = 1; i <= waits + 6; i++) begin
      @(negedge clk);
      ad_in = 8'($urandom);
      req_ie = 1'($urandom);
      req_start = (stray_start && i == 2);
      if (i == 1) req_addr = 20'($urandom);
      if (i == waits + 3) bus_ready = 1;
      if (hold_mid && i == 2) hold_req = 1;
      if (hold_mid && i == waits + 7 - 2) hold_req = 0;
    end
    hold_req = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    run_cycle(1, 1, 20'hA5C3E, 8'h00, 2'b11, 0, 0, 0);
    run_cycle(1, 1, 20'h3_1234, 8'h00, 2'b01, 2, 0, 0);
    run_cycle(0, 1, 20'hF_0F0F, 8'h5A, 2'b00, 1, 0, 0);
    run_cycle(1, 0, 20'h7_00FF, 8'h00, 2'b10, 0, 0, 0);
    run_cycle(0, 0, 20'hC_8001, 8'hC3, 2'b11, 3, 1, 0);
    run_cycle(1, 1, 20'h9_ABCD, 8'h00, 2'b01, 1, 0, 1);
    // hold from idle, with start ignored while held (R10, R1)
    @(negedge clk); hold_req = 1; req_start = 1;
    repeat (4) @(negedge clk);
    hold_req = 0; req_start = 0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 25; k++)
      run_cycle(1'($urandom), 1'($urandom), 20'($urandom), 8'($urandom),
                2'($urandom), k % 4, 1'($urandom), (k % 5) == 0);
    repeat (3) @(negedge clk);
    rst = 1; repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule